// File: doc/BRIEF.md
# Static Dataflow Actor Node

This block is one instruction of a dataflow program built directly in hardware. It has a left and a right operand slot. When both slots hold a value and the output edge is empty, the node fires. Firing computes one arithmetic result, chosen at build time from add, subtract or multiply, and places it on the output edge as a token. Nothing else triggers the node: there is no program counter and no sequencer. A value is 8 bits wide and travels with a valid bit, and the pair forms a token.

Each operand can be wired to an upstream token stream or fixed as a build-time constant. A constant operand counts as permanently present and never takes a token. The operands are read as signed or unsigned integers, as chosen per node. The result token also carries a fixed destination descriptor, so the surrounding fabric can route it to the left or right operand of another node or to an output port.

Every edge follows the static rule and holds at most one token. Inputs use valid/ready. A slot raises its ready only while it is empty, so an upstream producer holding a token must keep valid and data steady until the slot takes it. The output uses valid/ready too. A result stays on the output, unchanged, until the consumer raises ready. While the output is occupied the node does not fire again. Full operand slots therefore stall, and their ready signals stay low, which passes back-pressure upstream one edge at a time.

Top module: `dfn_actor_node`

## Requirements
- R1: A token operand slot shows ready high exactly when it is empty. A token is taken on a clock edge where both valid and ready are high.
- R2: The node fires on the first edge where both operands are present and the output is empty. On that edge it loads the result into the output and empties every token slot. A single operand never causes a firing.
- R3: A full slot keeps its value and holds ready low until a firing consumes it. At most one token sits on each input edge.
- R4: A result token keeps out_valid high and out_data stable until an edge where out_ready is high. After that edge out_valid is low.
- R5: An immediate operand is always present and holds its ready low. Its input valid and data have no effect on the result.
- R6: The operation is selected at build time: sum, difference (left minus right) or product. It is truncated to 8 bits and wraps modulo 256 with no flag.
- R7: In signed mode the operands are read as two's complement, and the product is the low 8 bits of the signed 16-bit product.
- R8: out_dst_kind is constant: 0 means left operand of the target node, 1 means right operand, 2 means output port. out_dst_idx gives the target node or port number.
- R9: A synchronous active-high reset empties both slots and the output token.
- R10: While a result waits on the output, the node does not fire, even when both operands are present. The operands stay full until the edge after the output drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_a_valid | input | 1 | Left operand token valid |
| in_a_ready | output | 1 | Left slot empty and able to take a token |
| in_a_data | input | DATA_W | Left operand value |
| in_b_valid | input | 1 | Right operand token valid |
| in_b_ready | output | 1 | Right slot empty and able to take a token |
| in_b_data | input | DATA_W | Right operand value |
| out_valid | output | 1 | Result token present |
| out_ready | input | 1 | Consumer takes the result token |
| out_data | output | DATA_W | Result value |
| out_dst_kind | output | 2 | Destination kind: 0 left operand, 1 right operand, 2 output port |
| out_dst_idx | output | DST_IDX_W | Destination node or port number |

## Verification
The assertions check on every cycle that a taken token fills its slot, that a full slot keeps its value until a firing consumes it, that a consumed token slot is empty afterwards, that a result appears only after both operands were present, and that a waiting result is held stable and leaves after the handshake. Several behaviours can only be shown by the bench's scenarios. These are the arithmetic values, including wrap-around and signed products; the fact that immediate inputs are ignored; the stall of full operands behind an occupied output; the reset of a loaded node; and the constant destination fields.

// File: rtl/dfn_pkg.sv
package dfn_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_LEFT  = 2'd0,
    DST_RIGHT = 2'd1,
    DST_PORT  = 2'd2
  } dst_kind_e;

endpackage

// File: rtl/dfn_operand_slot.sv
module dfn_operand_slot #(
  parameter int          DATA_W  = 8,
  parameter bit          IMM_EN  = 1'b0,
  parameter logic [DATA_W-1:0] IMM_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              consume,
  output logic              present,
  output logic [DATA_W-1:0] value
);

  generate
    if (IMM_EN) begin : g_imm
      // constant operand: always present, never takes a token
      logic imm_unused;
      assign imm_unused = &{1'b0, in_valid, in_data, consume, clk, rst};
      assign in_ready   = 1'b0;
      assign present    = 1'b1;
      assign value      = IMM_VAL;
    end else begin : g_tok
      logic              full_q;
      logic [DATA_W-1:0] val_q;
      logic              take;

      assign take     = in_valid && !full_q;
      assign in_ready = !full_q;
      assign present  = full_q;
      assign value    = val_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          full_q <= 1'b0;
          val_q  <= '0;
        end else if (take) begin
          full_q <= 1'b1;
          val_q  <= in_data;
        end else if (consume) begin
          full_q <= 1'b0;
        end
      end

      // R1: an accepted token fills the slot
      p_accept_fills_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (present && value == $past(in_data)));

      // R3: a full slot keeps its token until consumed
      p_slot_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (present && !consume) |=> (present && $stable(value)));

      // R2: a consumed token leaves its slot empty
      p_consume_empties_r2: assert property (@(posedge clk) disable iff (rst)
        consume |=> !present);
    end
  endgenerate

endmodule

// File: rtl/dfn_alu.sv
module dfn_alu #(
  parameter int               DATA_W = 8,
  parameter dfn_pkg::alu_op_e OP     = dfn_pkg::ALU_ADD,
  parameter bit               SIGNED_OPS = 1'b0
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);

  localparam int PROD_W = 2 * DATA_W;

  generate
    if (OP == dfn_pkg::ALU_ADD) begin : g_add
      assign res = opa + opb;
    end else if (OP == dfn_pkg::ALU_SUB) begin : g_sub
      assign res = opa - opb;
    end else begin : g_mul
      logic [PROD_W-1:0] prod;
      if (SIGNED_OPS) begin : g_smul
        logic signed [PROD_W-1:0] sprod;
        assign sprod = PROD_W'($signed(opa)) * PROD_W'($signed(opb));
        assign prod  = sprod;
      end else begin : g_umul
        assign prod = PROD_W'(opa) * PROD_W'(opb);
      end
      logic hi_unused;
      assign hi_unused = &{1'b0, prod[PROD_W-1:DATA_W]};
      assign res = prod[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/dfn_result_reg.sv
module dfn_result_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [DATA_W-1:0] res_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= res_in;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R4: a waiting result is held unchanged
  p_hold_result_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4: the handshake removes the result
  p_drain_result_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid);

  // R9: reset empties the output edge
  p_reset_clears_r9: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

// File: rtl/dfn_actor_node.sv
module dfn_actor_node #(
  parameter int                 DATA_W     = 8,
  parameter dfn_pkg::alu_op_e   OP         = dfn_pkg::ALU_ADD,
  parameter bit                 SIGNED_OPS = 1'b0,
  parameter bit                 IMM_A_EN   = 1'b0,
  parameter logic [DATA_W-1:0]  IMM_A      = '0,
  parameter bit                 IMM_B_EN   = 1'b0,
  parameter logic [DATA_W-1:0]  IMM_B      = '0,
  parameter dfn_pkg::dst_kind_e DST_KIND   = dfn_pkg::DST_PORT,
  parameter int                 DST_IDX_W  = 6,
  parameter logic [DST_IDX_W-1:0] DST_IDX  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_a_valid,
  output logic                 in_a_ready,
  input  logic [DATA_W-1:0]    in_a_data,
  input  logic                 in_b_valid,
  output logic                 in_b_ready,
  input  logic [DATA_W-1:0]    in_b_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_data,
  output logic [1:0]           out_dst_kind,
  output logic [DST_IDX_W-1:0] out_dst_idx
);

  logic              a_present, b_present;
  logic [DATA_W-1:0] a_val, b_val, alu_res;
  logic              fire;

  assign fire = a_present && b_present && !out_valid;

  dfn_operand_slot #(.DATA_W(DATA_W), .IMM_EN(IMM_A_EN), .IMM_VAL(IMM_A)) u_slot_a (
    .clk(clk), .rst(rst),
    .in_valid(in_a_valid), .in_ready(in_a_ready), .in_data(in_a_data),
    .consume(fire), .present(a_present), .value(a_val)
  );

  dfn_operand_slot #(.DATA_W(DATA_W), .IMM_EN(IMM_B_EN), .IMM_VAL(IMM_B)) u_slot_b (
    .clk(clk), .rst(rst),
    .in_valid(in_b_valid), .in_ready(in_b_ready), .in_data(in_b_data),
    .consume(fire), .present(b_present), .value(b_val)
  );

  dfn_alu #(.DATA_W(DATA_W), .OP(OP), .SIGNED_OPS(SIGNED_OPS)) u_alu (
    .opa(a_val), .opb(b_val), .res(alu_res)
  );

  dfn_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk(clk), .rst(rst), .fire(fire), .res_in(alu_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  assign out_dst_kind = DST_KIND;
  assign out_dst_idx  = DST_IDX;

  // R2: a new result only appears after both operands were present
  p_fire_needs_both_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(a_present && b_present));

  // R10: a waiting result blocks the next result from overwriting it
  p_static_edge_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

endmodule

// File: tb/dfn_actor_node_tb.sv
module dfn_actor_node_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a_v = 1'b0, b_v = 1'b0, o_rdy = 1'b0;
  logic [7:0] a_d = '0, b_d = '0;

  always #5 clk = ~clk;

  logic       i_ar, i_br, i_ov; logic [7:0] i_od; logic [1:0] i_dk; logic [5:0] i_di;
  logic       s_ar, s_br, s_ov; logic [7:0] s_od; logic [1:0] s_dk; logic [5:0] s_di;
  logic       m_ar, m_br, m_ov; logic [7:0] m_od; logic [1:0] m_dk; logic [5:0] m_di;

  dfn_actor_node #(.OP(dfn_pkg::ALU_ADD), .DST_KIND(dfn_pkg::DST_RIGHT), .DST_IDX(6'd9)) dut_i (
    .clk(clk), .rst(rst), .in_a_valid(a_v), .in_a_ready(i_ar), .in_a_data(a_d),
    .in_b_valid(b_v), .in_b_ready(i_br), .in_b_data(b_d),
    .out_valid(i_ov), .out_ready(o_rdy), .out_data(i_od), .out_dst_kind(i_dk), .out_dst_idx(i_di));

  dfn_actor_node #(.OP(dfn_pkg::ALU_SUB), .IMM_B_EN(1'b1), .IMM_B(8'd5),
                   .DST_KIND(dfn_pkg::DST_LEFT), .DST_IDX(6'd3)) dut_sub (
    .clk(clk), .rst(rst), .in_a_valid(a_v), .in_a_ready(s_ar), .in_a_data(a_d),
    .in_b_valid(b_v), .in_b_ready(s_br), .in_b_data(b_d),
    .out_valid(s_ov), .out_ready(o_rdy), .out_data(s_od), .out_dst_kind(s_dk), .out_dst_idx(s_di));

  dfn_actor_node #(.OP(dfn_pkg::ALU_MUL), .SIGNED_OPS(1'b1), .IMM_A_EN(1'b1), .IMM_A(8'hFD),
                   .DST_KIND(dfn_pkg::DST_PORT), .DST_IDX(6'd1)) dut_mul (
    .clk(clk), .rst(rst), .in_a_valid(a_v), .in_a_ready(m_ar), .in_a_data(a_d),
    .in_b_valid(b_v), .in_b_ready(m_br), .in_b_data(b_d),
    .out_valid(m_ov), .out_ready(o_rdy), .out_data(m_od), .out_dst_kind(m_dk), .out_dst_idx(m_di));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] exp_add(input logic [7:0] a, input logic [7:0] b);
    int s = int'(a) + int'(b);
    return s[7:0];
  endfunction
  function automatic logic [7:0] exp_sub(input logic [7:0] a);
    int s = int'(a) - 5;
    return s[7:0];
  endfunction
  function automatic logic [7:0] exp_mul(input logic [7:0] b);
    int s = -3 * int'($signed(b));
    return s[7:0];
  endfunction

  // {a, b}
  localparam logic [15:0] VECS [6] = '{
    {8'd3,   8'd4},
    {8'd200, 8'd100},
    {8'd0,   8'd0},
    {8'd255, 8'd1},
    {8'd128, 8'd128},
    {8'd17,  8'd250}
  };

  logic [7:0] held;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    cyc(2);
    rst = 1'b0;
    // R9: reset state
    chk("R9 out_valid after reset", i_ov, 0);
    chk("R9 a ready after reset", i_ar, 1);
    chk("R9 b ready after reset", i_br, 1);
    // R8: destination descriptors
    chk("R8 dut_i kind", i_dk, 1); chk("R8 dut_i idx", i_di, 9);
    chk("R8 dut_sub kind", s_dk, 0); chk("R8 dut_sub idx", s_di, 3);
    chk("R8 dut_mul kind", m_dk, 2); chk("R8 dut_mul idx", m_di, 1);

    for (int v = 0; v < 6; v++) begin
      a_d = VECS[v][15:8]; b_d = VECS[v][7:0];
      a_v = 1'b1; b_v = 1'b1;
      chk("R1 a ready empty", i_ar, 1);
      chk("R5 imm b ready low", s_br, 0);
      chk("R5 imm a ready low", m_ar, 0);
      cyc(1);
      a_v = 1'b0; b_v = 1'b0;
      b_d = 8'hA5;  // garbage on the immediate side must not matter (R5)
      chk("R3 a ready low when full", i_ar, 0);
      chk("R2 no result before fire", i_ov, 0);
      cyc(1);
      chk("R2 fired", i_ov, 1);
      chk("R6 add value", i_od, exp_add(VECS[v][15:8], VECS[v][7:0]));
      chk("R5 R6 sub with immediate", s_od, exp_sub(VECS[v][15:8]));
      chk("R7 signed mul with immediate", m_od, exp_mul(VECS[v][7:0]));
      chk("R2 slot emptied on fire", i_ar, 1);
      cyc(1);
      chk("R4 held valid", i_ov, 1);
      chk("R4 held data", i_od, exp_add(VECS[v][15:8], VECS[v][7:0]));
      o_rdy = 1'b1;
      cyc(1);
      o_rdy = 1'b0;
      chk("R4 cleared after handshake", i_ov, 0);
    end

    // R2: a single operand does not fire
    a_d = 8'd7; a_v = 1'b1;
    cyc(1); a_v = 1'b0;
    cyc(3);
    chk("R2 lone operand no fire", i_ov, 0);
    b_d = 8'd8; b_v = 1'b1;
    cyc(1); b_v = 1'b0;
    cyc(1);
    chk("R2 fire after second operand", i_od, 8'd15);
    held = i_od;

    // R10: full operands stall behind the occupied output
    a_d = 8'd1; b_d = 8'd2; a_v = 1'b1; b_v = 1'b1;
    cyc(1); a_v = 1'b0; b_v = 1'b0;
    cyc(3);
    chk("R10 output unchanged", i_od, held);
    chk("R10 output still valid", i_ov, 1);
    chk("R3 a still blocked", i_ar, 0);
    chk("R3 b still blocked", i_br, 0);
    o_rdy = 1'b1;
    cyc(1); o_rdy = 1'b0;
    chk("R10 drained", i_ov, 0);
    chk("R10 operands kept", i_ar, 0);
    cyc(1);
    chk("R10 refire valid", i_ov, 1);
    chk("R10 refire value", i_od, 8'd3);

    // R9: reset a loaded node
    a_d = 8'd50; a_v = 1'b1;
    cyc(1); a_v = 1'b0;
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    chk("R9 output cleared", i_ov, 0);
    chk("R9 a slot cleared", i_ar, 1);
    b_d = 8'd1; b_v = 1'b1;
    cyc(1); b_v = 1'b0;
    cyc(2);
    chk("R9 old operand gone", i_ov, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule